// File: doc/BRIEF.md
# Sign-Terminated Pulse Timer

This block drives a pulse whose length is a chosen number of clock cycles. A single down-counter times the pulse. The counter is one bit wider than the width value. Its extra top bit serves as a sign. When a pulse starts, the counter is preset to the requested width minus two. It then counts down by one per cycle. The pulse ends in the cycle where the counter first goes negative, so the top bit alone marks the end and no comparison against zero is needed. Only one subtractor of the widened size sits on the timing path.

A trigger arriving while the block is idle starts a pulse. A trigger arriving while the block is busy is dropped. With repeat enabled, the counter is preset again in its terminal cycle instead of stopping. The output then alternates between high and low stretches of the programmed length, and busy stays asserted until repeat is withdrawn.

Top module: `pgen_top`

## Requirements
- R1: While the synchronous reset `rst` is high, and in every cycle after it until a trigger is taken, `pulse_o` and `busy_o` are 0.
- R2: A trigger sampled at a clock edge while `busy_o` is 0 makes `busy_o` and `pulse_o` 1 from that edge on, starting a high stretch.
- R3: With `repeat_en` low, a pulse keeps `pulse_o` and `busy_o` high for exactly N consecutive cycles, where N is the value of `width_n` at the trigger edge. Both then return to 0.
- R4: A width value below 2 (0 or 1) behaves exactly like a width of 2.
- R5: A trigger sampled while `busy_o` is 1, including in the last high cycle, neither restarts nor stretches the pulse, and leaves the block idle afterwards.
- R6: With `repeat_en` high, `busy_o` stays 1 and `pulse_o` alternates between high and low stretches, starting with high. Each stretch is as long as the clamped `width_n` sampled at the edge that began it.
- R7: When `repeat_en` is low at the end of a stretch in repeat operation, the train stops: `busy_o` and `pulse_o` are 0 from the next cycle onward.
- R8: The largest width, 2^WIDTH_W - 1, gives a pulse of exactly that many cycles. While idle, the internal counter is always negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Start request, sampled at each rising edge |
| repeat_en | input | 1 | 1 selects a continuous alternating train, 0 selects a single pulse |
| width_n | input | WIDTH_W | Stretch length N in cycles, clamped to at least 2 |
| pulse_o | output | 1 | Timed pulse output |
| busy_o | output | 1 | High while a pulse or train is in progress |

## Verification
A counter preset that is off by one shows at the ports on the first pulse, as a high time of N-1 or N+1 cycles. Pulses of lengths 2, 5, 7, 9 and 255 expose this within a few hundred cycles. A sign bit that is never set, or that is set too early, shows as a pulse that never ends or that ends short. A wrong segment phase in repeat operation shows as a misplaced low stretch within the first 2N cycles. The reference model compares `pulse_o` and `busy_o` on every cycle, so any such fault is reported in the cycle it first appears.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

  // Which half of a repeat period the block is in.
  typedef enum logic {
    SEG_HIGH = 1'b0,
    SEG_LOW  = 1'b1
  } seg_e;

  // Effective stretch length: values below two are raised to two.
  function automatic int unsigned eff_width(input int unsigned n);
    return (n < 2) ? 2 : n;
  endfunction

  // Counter preset so that the sign bit appears in the N-th active cycle.
  function automatic int unsigned preset_of(input int unsigned n);
    return eff_width(n) - 2;
  endfunction

endpackage

// File: rtl/pgen_preset.sv
module pgen_preset #(
  parameter int WIDTH_W = 8,
  localparam int CW = WIDTH_W + 1
) (
  input  logic [WIDTH_W-1:0] width_n,
  output logic [CW-1:0]      preset_o
);
  import pgen_pkg::*;

  logic [31:0] wide_n;

  generate
    if (WIDTH_W >= 32) begin : g_trunc
      assign wide_n = width_n[31:0];
    end else begin : g_pad
      assign wide_n = {{(32-WIDTH_W){1'b0}}, width_n};
    end
  endgenerate

  int unsigned pre_full;
  always_comb begin
    pre_full = preset_of(wide_n);
    preset_o = pre_full[CW-1:0];
  end

  // Preset is never negative: the sign bit must be clear at load.
  always_comb begin
    assert_preset_nonneg_R4: assert (preset_o[CW-1] == 1'b0);
  end

endmodule

// File: rtl/pgen_counter.sv
module pgen_counter #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_en,
  input  logic          dec_en,
  input  logic [CW-1:0] preset_i,
  output logic          sign_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_dec;

  assign cnt_dec = cnt_q - CW'(1);
  assign sign_o  = cnt_q[CW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '1;
    end else if (load_en) begin
      cnt_q <= preset_i;
    end else if (dec_en) begin
      cnt_q <= cnt_dec;
    end
  end

  // A load takes the preset exactly.
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load_en |=> cnt_q == $past(preset_i));

  // An active, non-terminal cycle moves the count down by one.
  assert_count_R3: assert property (@(posedge clk) disable iff (rst)
    (dec_en && !load_en) |=> cnt_q == $past(cnt_q) - CW'(1));

  // Without load or decrement the count holds.
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!dec_en && !load_en) |=> $stable(cnt_q));

endmodule

// File: rtl/pgen_ctrl.sv
module pgen_ctrl
  import pgen_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic trig,
  input  logic repeat_en,
  input  logic sign_i,
  output logic active_o,
  output seg_e seg_o,
  output logic load_en,
  output logic dec_en
);

  logic active_q;
  seg_e seg_q;

  // Named events for the assertions.
  logic start_ev, term_ev, reload_ev, stop_ev;

  assign start_ev  = trig & ~active_q;
  assign term_ev   = active_q & sign_i;
  assign reload_ev = term_ev & repeat_en;
  assign stop_ev   = term_ev & ~repeat_en;

  assign load_en  = start_ev | reload_ev;
  assign dec_en   = active_q & ~term_ev;
  assign active_o = active_q;
  assign seg_o    = seg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      seg_q    <= SEG_HIGH;
    end else begin
      if (start_ev) begin
        active_q <= 1'b1;
        seg_q    <= SEG_HIGH;
      end else if (stop_ev) begin
        active_q <= 1'b0;
        seg_q    <= SEG_HIGH;
      end else if (reload_ev) begin
        seg_q    <= (seg_q == SEG_HIGH) ? SEG_LOW : SEG_HIGH;
      end
    end
  end

  // A start leaves the block active in a high stretch with a clear sign.
  assert_start_R2: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (active_q && seg_q == SEG_HIGH && !sign_i));

  // Until the sign bit shows, an active block stays active.
  assert_busy_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (active_q && !sign_i) |=> active_q);

  // Terminal cycle in one-shot operation ends the pulse.
  assert_end_R3: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> !active_q);

  // Terminal cycle in repeat operation flips the stretch and keeps running.
  assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
    reload_ev |=> (active_q && seg_q != $past(seg_q) && !sign_i));

  // Idle implies a negative count.
  assert_idle_sign_R8: assert property (@(posedge clk) disable iff (rst)
    !active_q |-> sign_i);

endmodule

// File: rtl/pgen_top.sv
module pgen_top #(
  parameter int WIDTH_W = 8,
  localparam int CW = WIDTH_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               trig,
  input  logic               repeat_en,
  input  logic [WIDTH_W-1:0] width_n,
  output logic               pulse_o,
  output logic               busy_o
);
  import pgen_pkg::*;

  logic [CW-1:0] preset;
  logic          sign;
  logic          active;
  seg_e          seg;
  logic          load_en;
  logic          dec_en;

  pgen_preset #(.WIDTH_W(WIDTH_W)) u_preset (
    .width_n  (width_n),
    .preset_o (preset)
  );

  pgen_counter #(.CW(CW)) u_counter (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .dec_en   (dec_en),
    .preset_i (preset),
    .sign_o   (sign)
  );

  pgen_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .trig      (trig),
    .repeat_en (repeat_en),
    .sign_i    (sign),
    .active_o  (active),
    .seg_o     (seg),
    .load_en   (load_en),
    .dec_en    (dec_en)
  );

  assign busy_o  = active;
  assign pulse_o = active & (seg == SEG_HIGH);

  // Output pulse only ever appears inside a busy period.
  assert_pulse_in_busy_R6: assert property (@(posedge clk) disable iff (rst)
    pulse_o |-> busy_o);

  // Reset leaves both outputs low.
  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!pulse_o && !busy_o));

endmodule

// File: tb/tb_pgen_top.sv
module tb_pgen_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trig = 1'b0;
  logic rep = 1'b0;
  logic [W-1:0] width = '0;
  logic pulse, busy;

  always #4 clk = ~clk;

  pgen_top #(.WIDTH_W(W)) dut (
    .clk(clk), .rst(rst), .trig(trig), .repeat_en(rep),
    .width_n(width), .pulse_o(pulse), .busy_o(busy)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  function automatic int clampw(input int n);
    if (n < 2) return 2;
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: remaining cycles of the current stretch.
  bit m_busy = 0;
  bit m_hi = 1;
  int m_left = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_hi = 1; m_left = 0;
    end else if (!m_busy) begin
      if (trig) begin
        m_busy = 1; m_hi = 1; m_left = clampw(int'(width));
      end
    end else begin
      m_left = m_left - 1;
      if (m_left == 0) begin
        if (rep) begin
          m_left = clampw(int'(width));
          m_hi = !m_hi;
        end else begin
          m_busy = 0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check(pulse === (m_busy && m_hi), {cur_req, " pulse_o"}, int'(pulse), int'(m_busy && m_hi));
      check(busy === m_busy, {cur_req, " busy_o"}, int'(busy), int'(m_busy));
    end
  end

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  // One-shot pulse; optional triggers during the pulse and in its last cycle.
  task automatic shot(input int w, input bit poke, input string req);
    int seen;
    seen = 0;
    cur_req = req;
    width = W'(w);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    while (busy && seen < 1000) begin
      if (pulse) seen++;
      trig = (poke && (seen == 2 || seen == clampw(w)));
      @(negedge clk);
    end
    trig = 1'b0;
    check(seen == clampw(w), {req, " high cycles"}, seen, clampw(w));
    check(!pulse && !busy, {req, " idle after"}, int'(busy), 0);
  endtask

  initial begin
    int hi;
    bit allbusy;
    int waitc;
    repeat (3) @(negedge clk);
    check(!pulse && !busy, "R1 during reset", int'(pulse | busy), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(!pulse && !busy, "R1 after reset", int'(pulse | busy), 0);

    shot(5, 0, "R3");
    shot(9, 0, "R3");
    shot(1, 0, "R4");
    shot(0, 0, "R4");
    shot(2, 0, "R4");
    shot(7, 1, "R5");
    repeat (4) @(negedge clk);
    check(!busy, "R5 stays idle", int'(busy), 0);
    shot(255, 0, "R8");

    // Repeat train: 3 high, 3 low, ...
    cur_req = "R6";
    rep = 1'b1;
    width = W'(3);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    check(busy && pulse, "R2 start", int'(pulse), 1);
    hi = 0; allbusy = 1;
    for (int i = 0; i < 12; i++) begin
      if (pulse) hi++;
      if (!busy) allbusy = 0;
      @(negedge clk);
    end
    check(hi == 6, "R6 high count", hi, 6);
    check(allbusy, "R6 busy held", int'(allbusy), 1);
    width = W'(5);
    repeat (14) @(negedge clk);

    cur_req = "R7";
    rep = 1'b0;
    waitc = 0;
    while (busy && waitc < 20) begin
      waitc++;
      @(negedge clk);
    end
    check(!busy, "R7 train stopped", int'(busy), 0);
    repeat (3) @(negedge clk);
    check(!busy && !pulse, "R7 stays idle", int'(busy | pulse), 0);

    summary();
  end

endmodule